// File: doc/BRIEF.md
# Dual-Channel DAC Sample Aligner

This block sits between a register bus and a two-channel digital-to-analog converter. Software writes conversion samples through a small write-only port. The block turns each sample into a 12-bit converter code and holds that code on a registered output, one code per channel (A and B). Each channel has its own sample register. When the dual-data mode is on, a single 32-bit write fills both channels at the same time.

Each channel has its own shift stage. The stage moves the sample left or right by up to 15 places. A right shift is rounded to nearest. Any result wider than 12 bits is clamped to the largest code.

Each loaded channel raises a pending flag, which stays up until the conversion scheduler acknowledges that it has taken the sample. A new sample that replaces one still pending raises a sticky overrun flag. Only an explicit clear pulse removes that flag.

Top module: `dac_sample_aligner`

## Requirements
- R1: After a synchronous reset both codes are 0, both pending flags and both overrun flags are 0, and the configuration reads as dual mode off with both shifts at amount 0.
- R2: `wr_sel` selects the target of a write: 0 is the channel A sample register, 1 is the channel B sample register, 2 is the configuration register, and 3 is ignored. A write to a sample register shows up on the code output after the next rising clock edge.
- R3: The configuration word holds five fields. Bit 0 turns dual mode on. Bits 7:4 are the channel A shift amount and bit 8 is the channel A direction (1 = left). Bits 15:12 are the channel B shift amount and bit 16 is the channel B direction (1 = left). The new configuration applies to all sample writes that follow.
- R4: In dual mode, a write to select 0 loads channel A from bits 15:0 and channel B from bits 31:16, and it raises both pending flags.
- R5: With dual mode off, bits 31:16 of a select-0 write are ignored. Channel B code and channel B pending do not change.
- R6: With a shift amount of 0 in either direction, the code equals bits 11:0 of the 16-bit sample field.
- R7: A right shift by n (n ≥ 1) acts on the full 16-bit field. It computes (field + 2^(n-1)) >> n.
- R8: A left shift by n acts on bits 11:0 of the field and fills the vacated low bits with zeros.
- R9: Any shifted or rounded result above 0xFFF gives the code 0xFFF.
- R10: Loading a channel sets its pending flag. An acknowledge with no load in the same cycle clears the flag at the next edge. When a load and an acknowledge arrive in the same cycle, the load wins.
- R11: A load into a channel whose flag is pending and that gets no acknowledge in the same cycle sets that channel's overrun flag. The flag stays set until the channel's `ovr_clr` bit is pulsed. A new overrun in the same cycle as a clear wins over the clear.
- R12: A write to select 1 loads channel B from bits 15:0 only, in either mode. Channel A is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 32 | Write data |
| ack_a | input | 1 | Scheduler has consumed the channel A sample |
| ack_b | input | 1 | Scheduler has consumed the channel B sample |
| ovr_clr | input | 2 | Overrun clear pulse, bit 0 for A, bit 1 for B |
| code_a | output | 12 | Aligned channel A code |
| code_b | output | 12 | Aligned channel B code |
| pend_a | output | 1 | Channel A sample pending |
| pend_b | output | 1 | Channel B sample pending |
| ovr_a | output | 1 | Channel A overrun, sticky |
| ovr_b | output | 1 | Channel B overrun, sticky |

## Verification
The alignment path is driven with a set of stimulus patterns, each chosen to separate one behaviour from another:
- Unshifted samples with junk in the top nibble show whether the high field bits really are dropped.
- Right shifts with the discarded half just below and exactly at the rounding point separate rounding from truncation.
- Left shifts with and without bits crossing bit 11 separate a clamped result from a wrapped one.
- A rounding carry out of 0xFFF8 shows whether the clamp also covers carries from rounding.

Writes to select 0 are made with the dual bit on and with it off, and writes to select 1 are made in dual mode. Together these show which channel each half-word reaches.

Directed sequences check the flag rules:
- back-to-back loads with no acknowledge,
- a load and an acknowledge in the same cycle,
- a load and an overrun clear in the same cycle.

// File: rtl/dac_align_pkg.sv
package dac_align_pkg;
    localparam int FIELD_W = 16;
    localparam int CODE_W  = 12;
    localparam int AMT_W   = 4;
    localparam int NCH     = 2;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int TMP_W   = FIELD_W + CODE_W + 1;

    typedef enum logic [1:0] {
        SEL_SAMP_A = 2'd0,
        SEL_SAMP_B = 2'd1,
        SEL_CFG    = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic             left;
        logic [AMT_W-1:0] amt;
    } shift_cfg_t;

    typedef struct packed {
        logic       dual;
        shift_cfg_t sh_b;
        shift_cfg_t sh_a;
    } cfg_t;

    // Shift, round and clamp one sample field into a converter code.
    function automatic logic [CODE_W-1:0] align_sample(
        input logic [FIELD_W-1:0] s,
        input shift_cfg_t         c
    );
        logic [TMP_W-1:0] t;
        logic [TMP_W-1:0] half;
        half = '0;
        if (c.amt == '0) begin
            t = {{(TMP_W-CODE_W){1'b0}}, s[CODE_W-1:0]};
        end else if (c.left) begin
            t = {{(TMP_W-CODE_W){1'b0}}, s[CODE_W-1:0]} << c.amt;
        end else begin
            half = {{(TMP_W-1){1'b0}}, 1'b1} << (c.amt - {{(AMT_W-1){1'b0}}, 1'b1});
            t = ({{(TMP_W-FIELD_W){1'b0}}, s} + half) >> c.amt;
        end
        if (|t[TMP_W-1:CODE_W])
            return {CODE_W{1'b1}};
        return t[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/dac_cfg_reg.sv
module dac_cfg_reg
    import dac_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg.dual      <= wdata[0];
            cfg.sh_a.amt  <= wdata[7:4];
            cfg.sh_a.left <= wdata[8];
            cfg.sh_b.amt  <= wdata[15:12];
            cfg.sh_b.left <= wdata[16];
        end
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_align_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FIELD_W-1:0] sample,
    input  shift_cfg_t         shift,
    input  logic               ack,
    input  logic               ovr_clr,
    output logic [CODE_W-1:0]  code,
    output logic               pend,
    output logic               ovr
);
    logic [CODE_W-1:0] aligned;

    always_comb aligned = align_sample(sample, shift);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            pend <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (load)
                code <= aligned;
            if (load)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
            if (load && pend && !ack)
                ovr <= 1'b1;
            else if (ovr_clr)
                ovr <= 1'b0;
        end
    end

    // R10
    pend_set_by_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(load));
    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !load) |=> !pend);
    // R11
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(load && pend && !ack));
    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code));
endmodule

// File: rtl/dac_sample_aligner.sv
module dac_sample_aligner
    import dac_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              ack_a,
    input  logic              ack_b,
    input  logic [1:0]        ovr_clr,
    output logic [11:0]       code_a,
    output logic [11:0]       code_b,
    output logic              pend_a,
    output logic              pend_b,
    output logic              ovr_a,
    output logic              ovr_b
);
    cfg_t               cfg_q;
    wr_sel_e            sel;
    logic [NCH-1:0]     ld;
    logic [NCH-1:0]     ack;
    logic [NCH-1:0]     pend;
    logic [NCH-1:0]     ovr;
    logic [FIELD_W-1:0] samp [NCH];
    logic [CODE_W-1:0]  code [NCH];
    shift_cfg_t         sh   [NCH];

    always_comb sel = wr_sel_e'(wr_sel);

    dac_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && sel == SEL_CFG),
        .wdata (wr_data),
        .cfg   (cfg_q)
    );

    always_comb begin
        ld[0]   = wr_en && sel == SEL_SAMP_A;
        ld[1]   = wr_en && (sel == SEL_SAMP_B || (sel == SEL_SAMP_A && cfg_q.dual));
        samp[0] = wr_data[FIELD_W-1:0];
        samp[1] = (sel == SEL_SAMP_A) ? wr_data[WORD_W-1:FIELD_W] : wr_data[FIELD_W-1:0];
        sh[0]   = cfg_q.sh_a;
        sh[1]   = cfg_q.sh_b;
        ack     = {ack_b, ack_a};
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dac_chan u_ch (
            .clk     (clk),
            .rst     (rst),
            .load    (ld[i]),
            .sample  (samp[i]),
            .shift   (sh[i]),
            .ack     (ack[i]),
            .ovr_clr (ovr_clr[i]),
            .code    (code[i]),
            .pend    (pend[i]),
            .ovr     (ovr[i])
        );
    end

    assign code_a = code[0];
    assign code_b = code[1];
    assign pend_a = pend[0];
    assign pend_b = pend[1];
    assign ovr_a  = ovr[0];
    assign ovr_b  = ovr[1];

    // R5
    single_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && !cfg_q.dual) |=> $stable(code_b));
    // R4
    dual_loads_both_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && cfg_q.dual) |=> (pend_a && pend_b));
    // R12
    sel_b_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> $stable(code_a));
    // R2
    sel_none_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> ($stable(code_a) && $stable(code_b)));
endmodule

// File: tb/tb_dac_sample_aligner.sv
module tb_dac_sample_aligner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        ack_a = 1'b0;
    logic        ack_b = 1'b0;
    logic [1:0]  ovr_clr = 2'b00;
    logic [11:0] code_a, code_b;
    logic        pend_a, pend_b, ovr_a, ovr_b;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dac_sample_aligner dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_a(ack_a), .ack_b(ack_b), .ovr_clr(ovr_clr),
        .code_a(code_a), .code_b(code_b), .pend_a(pend_a), .pend_b(pend_b),
        .ovr_a(ovr_a), .ovr_b(ovr_b)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic [1:0]  sel;
        logic [31:0] data;
        logic [11:0] exp_a;
        logic [11:0] exp_b;
    } vec_t;

    // cfg: bit0 dual, [7:4] A amount, bit8 A left, [15:12] B amount, bit16 B left
    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0001, 2'd0, 32'h0ABC_0123, 12'h123, 12'hABC}, // R4 R6
        '{32'h0000_4041, 2'd0, 32'h1237_1238, 12'h124, 12'h123}, // R7 round up/down
        '{32'h0001_3141, 2'd0, 32'hF0FF_0012, 12'h120, 12'h7F8}, // R8
        '{32'h0001_1041, 2'd0, 32'h0800_FFF8, 12'hFFF, 12'hFFF}, // R9
        '{32'h0000_0000, 2'd0, 32'h0555_0321, 12'h321, 12'hFFF}, // R5
        '{32'h0000_1000, 2'd1, 32'h0000_0456, 12'h321, 12'h22B}, // R12 R7
        '{32'h0000_0001, 2'd1, 32'hFFFF_0789, 12'h321, 12'h789}, // R12 dual
        '{32'h0000_F0F1, 2'd0, 32'h3FFF_8000, 12'h001, 12'h000}, // R7 amount 15
        '{32'h0000_0101, 2'd0, 32'hFABC_F123, 12'h123, 12'hABC}  // R6 both directions
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_both();
        @(negedge clk);
        ack_a = 1'b1; ack_b = 1'b1;
        @(negedge clk);
        ack_a = 1'b0; ack_b = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 code_a", {20'd0, code_a}, 32'd0);
        check("R1 code_b", {20'd0, code_b}, 32'd0);
        check("R1 pend", {30'd0, pend_b, pend_a}, 32'd0);
        check("R1 ovr", {30'd0, ovr_b, ovr_a}, 32'd0);
        // R1: shifts at amount 0 and dual off after reset
        wr(2'd0, 32'h5555_F876);
        check("R1 shift0 code_a", {20'd0, code_a}, 32'h876);
        check("R1 dual off code_b", {20'd0, code_b}, 32'd0);
        ack_both();

        for (int i = 0; i < NV; i++) begin
            logic ea, eb;
            wr(2'd2, TBL[i].cfg);
            wr(TBL[i].sel, TBL[i].data);
            ea = (TBL[i].sel == 2'd0);
            eb = (TBL[i].sel == 2'd1) || (TBL[i].sel == 2'd0 && TBL[i].cfg[0]);
            check($sformatf("R2/R3 vec%0d code_a", i), {20'd0, code_a}, {20'd0, TBL[i].exp_a});
            check($sformatf("R2/R3 vec%0d code_b", i), {20'd0, code_b}, {20'd0, TBL[i].exp_b});
            check($sformatf("R10 vec%0d pend", i), {30'd0, pend_b, pend_a}, {30'd0, eb, ea});
            ack_both();
            check($sformatf("R10 vec%0d ack clears", i), {30'd0, pend_b, pend_a}, 32'd0);
        end

        wr(2'd2, 32'h0);
        // R2: select 3 ignored
        wr(2'd3, 32'hFFFF_FFFF);
        check("R2 sel3 code_a", {20'd0, code_a}, 32'h123);
        check("R2 sel3 code_b", {20'd0, code_b}, 32'hABC);
        check("R2 sel3 pend", {30'd0, pend_b, pend_a}, 32'd0);

        // R11: overrun on back-to-back loads
        wr(2'd0, 32'h0000_0011);
        check("R10 pend_a set", {31'd0, pend_a}, 32'd1);
        check("R11 no ovr yet", {31'd0, ovr_a}, 32'd0);
        wr(2'd0, 32'h0000_0022);
        check("R11 ovr_a set", {31'd0, ovr_a}, 32'd1);
        check("R11 overwrite code", {20'd0, code_a}, 32'h022);
        check("R11 ovr_b clear", {31'd0, ovr_b}, 32'd0);

        @(negedge clk); ovr_clr = 2'b01;
        @(negedge clk); ovr_clr = 2'b00;
        check("R11 clear", {31'd0, ovr_a}, 32'd0);
        check("R10 pend held", {31'd0, pend_a}, 32'd1);

        // R10: load with ack in the same cycle, no overrun
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h33; ack_a = 1'b1;
        @(negedge clk); wr_en = 1'b0; ack_a = 1'b0;
        check("R10 load beats ack", {31'd0, pend_a}, 32'd1);
        check("R11 ack avoids ovr", {31'd0, ovr_a}, 32'd0);
        check("R10 code", {20'd0, code_a}, 32'h033);

        // R11: set beats clear
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h44; ovr_clr = 2'b01;
        @(negedge clk); wr_en = 1'b0; ovr_clr = 2'b00;
        check("R11 set beats clear", {31'd0, ovr_a}, 32'd1);

        @(negedge clk); ack_a = 1'b1;
        @(negedge clk); ack_a = 1'b0;
        check("R10 ack alone clears", {31'd0, pend_a}, 32'd0);
        check("R11 sticky after ack", {31'd0, ovr_a}, 32'd1);

        done = 1'b1;
        report();
    end
endmodule